// File: doc/BRIEF.md
# Three-Cycle Burst Protocol Monitor

This block is a passive observer attached to a valid-qualified stream that feeds a consumer taking samples in fixed groups of three. The consumer cannot stall once a group starts: the input valid must be held high for three back-to-back cycles. The consumer answers with two output samples per group of three, a 3-in to 2-out rate, and it raises output valid in the second and third cycles of the group only.

The monitor follows the position of each group with a three-state tracker: idle, one cycle seen, two cycles seen. It flags two kinds of violation. The first is input valid dropping in the middle of a group. The second is output valid that does not line up with the second and third group cycles. It has no view of data values.

For each violation cycle it gives a single-cycle error indication. It also keeps a sticky flag that stays set until reset, and a count of groups that finished cleanly.

Top module: `burst3_monitor`

## Requirements
- R1: Three consecutive cycles with `in_vld` high form one group. The first high cycle after idle, or after a completed group, is cycle 1.
- R2: If `in_vld` is low while a group is at cycle 2 or 3, `err_pulse` is high in that same cycle. The tracker then returns to idle, and the next high `in_vld` starts a new group at cycle 1.
- R3: In group cycles 2 and 3, `out_vld` must be high. If it is low there, `err_pulse` is high in that same cycle.
- R4: `out_vld` high in group cycle 1, or in any cycle that is not part of a group, sets `err_pulse` in that same cycle.
- R5: A new group may start in the cycle right after the third cycle of the previous one. Holding `in_vld` high for six cycles, with correct `out_vld`, gives two clean groups.
- R6: `err_sticky` rises at the clock edge that ends any cycle with `err_pulse` high. It stays high until reset. `err_pulse` is low in every cycle without a violation.
- R7: `burst_cnt` goes up by one at the edge that ends the third cycle of a group with no violation in any of its three cycles. Otherwise it is unchanged. It wraps modulo 2^CNT_W.
- R8: While reset is held, and right after it, `err_sticky` is 0 and `burst_cnt` is 0. With both valids low, `err_pulse` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Valid on the consumer's input side |
| out_vld | input | 1 | Valid on the consumer's output side |
| err_pulse | output | 1 | High in each cycle with a violation |
| err_sticky | output | 1 | Set by any violation; cleared only by reset |
| burst_cnt | output | CNT_W | Count of groups completed without violation |

## Verification
The bench drives a single clean group and a six-cycle run of two groups, which separate correct counting from premature restarts. It drops valid after the first and after the second group cycle to show that the abort path works from both positions. A four-cycle run followed by a drop confirms that the fourth cycle opens a fresh group, not a continuation. Misplaced output valid (too early, missing, or outside any group) shows that only the output check fires, and that the tainted group is not counted. A long run of clean groups with a narrow counter exposes the wrap.

// File: rtl/burst3_monitor.sv
module burst3_monitor #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_vld,
  input  logic             out_vld,
  output logic             err_pulse,
  output logic             err_sticky,
  output logic [CNT_W-1:0] burst_cnt
);

  typedef enum logic [1:0] {IDLE, GOT1, GOT2} pos_t;

  pos_t pos;
  logic bad;

  logic in_burst, drop_err, out_want, out_err, last;

  assign in_burst  = (pos != IDLE);
  assign drop_err  = in_burst & ~in_vld;
  assign out_want  = in_vld & in_burst;
  assign out_err   = out_vld ^ out_want;
  assign last      = in_vld & (pos == GOT2);
  assign err_pulse = drop_err | out_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos        <= IDLE;
      bad        <= 1'b0;
      err_sticky <= 1'b0;
      burst_cnt  <= '0;
    end else begin
      if (!in_vld)            pos <= IDLE;
      else if (pos == IDLE)   pos <= GOT1;
      else if (pos == GOT1)   pos <= GOT2;
      else                    pos <= IDLE;

      if (in_vld && !last) bad <= out_err | (in_burst & bad);
      else                 bad <= 1'b0;

      if (last && !bad && !out_err) burst_cnt <= burst_cnt + 1'b1;

      if (err_pulse) err_sticky <= 1'b1;
    end
  end

  // R6
  p_sticky_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err_sticky |=> err_sticky);
  p_sticky_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |=> err_sticky);
  // R7
  p_cnt_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_cnt != $past(burst_cnt)) |-> (burst_cnt == CNT_W'($past(burst_cnt) + 1'b1)));
  // R1
  p_cnt_needs_vld_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_cnt != $past(burst_cnt)) |-> ($past(in_vld) && !$past(err_pulse)));
  // R2
  p_drop_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_burst && !in_vld) |-> err_pulse);
  // R4
  p_out_early_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_burst && out_vld) |-> err_pulse);

endmodule

// File: tb/burst3_monitor_tb.sv
module burst3_monitor_tb;
  localparam int CW = 4;
  localparam int MODV = 1 << CW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_vld = 1'b0;
  logic out_vld = 1'b0;
  logic err_pulse, err_sticky;
  logic [CW-1:0] burst_cnt;

  int n_chk = 0;
  int n_fail = 0;
  int exp_cnt = 0;

  always #4 clk = ~clk;

  burst3_monitor #(.CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .out_vld(out_vld),
    .err_pulse(err_pulse), .err_sticky(err_sticky), .burst_cnt(burst_cnt)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_vld = 1'b0; out_vld = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    exp_cnt = 0;
  endtask

  // one cycle: drive at negedge, check combinational error shortly after
  task automatic cyc(input bit iv, input bit ov, input bit exp_err, input string req);
    @(negedge clk);
    in_vld = iv; out_vld = ov;
    #1;
    chk(err_pulse == exp_err, req, err_pulse, exp_err);
  endtask

  task automatic good_burst();
    cyc(1, 0, 0, "R1");
    cyc(1, 1, 0, "R3");
    cyc(1, 1, 0, "R3");
    exp_cnt = (exp_cnt + 1) % MODV;
  endtask

  task automatic idle_check(input bit exp_sticky, input string req);
    cyc(0, 0, 0, req);
    chk(err_sticky == exp_sticky, {req, " sticky"}, err_sticky, exp_sticky);
    chk(burst_cnt == exp_cnt, {req, " count"}, burst_cnt, exp_cnt);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0; in_vld = 1'b0; out_vld = 1'b0;
    #1;
    chk(err_sticky == 0, "R8 sticky", err_sticky, 0);
    chk(burst_cnt == 0, "R8 count", burst_cnt, 0);
    chk(err_pulse == 0, "R8 pulse", err_pulse, 0);
    do_reset();
    idle_check(0, "R8");
  endtask

  task automatic t_single();
    do_reset();
    good_burst();
    idle_check(0, "R1");
  endtask

  task automatic t_back2back();
    do_reset();
    good_burst();
    good_burst();
    idle_check(0, "R5");
  endtask

  task automatic t_drop_after1();
    do_reset();
    cyc(1, 0, 0, "R1");
    cyc(0, 0, 1, "R2");
    idle_check(1, "R6");
    good_burst();
    idle_check(1, "R2");
    do_reset();
    idle_check(0, "R6");
  endtask

  task automatic t_drop_after2();
    do_reset();
    cyc(1, 0, 0, "R1");
    cyc(1, 1, 0, "R3");
    cyc(0, 0, 1, "R2");
    idle_check(1, "R2");
  endtask

  task automatic t_four_then_drop();
    do_reset();
    good_burst();
    cyc(1, 0, 0, "R5");
    cyc(0, 0, 1, "R5");
    idle_check(1, "R5");
  endtask

  task automatic t_out_first();
    do_reset();
    cyc(1, 1, 1, "R4");
    cyc(1, 1, 0, "R3");
    cyc(1, 1, 0, "R3");
    idle_check(1, "R7");
  endtask

  task automatic t_out_idle();
    do_reset();
    cyc(0, 1, 1, "R4");
    idle_check(1, "R4");
  endtask

  task automatic t_out_missing();
    do_reset();
    cyc(1, 0, 0, "R1");
    cyc(1, 0, 1, "R3");
    cyc(1, 1, 0, "R3");
    idle_check(1, "R7");
  endtask

  task automatic t_wrap();
    do_reset();
    for (int i = 0; i < MODV - 1; i++) good_burst();
    idle_check(0, "R7");
    good_burst();
    idle_check(0, "R7");
  endtask

  initial begin
    t_reset();
    t_single();
    t_back2back();
    t_drop_after1();
    t_drop_after2();
    t_four_then_drop();
    t_out_first();
    t_out_idle();
    t_out_missing();
    t_wrap();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 8);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule